// File: doc/BRIEF.md
# PFC Protection Supervisor

This block guards the power-factor-correction stage of a lamp ballast controller. Every clock it takes three digitized samples, each coded in millivolts: the bus-monitor divider, the error-amplifier inverting input and the PFC current-sense resistor. It also sees the PFC gate command. From these it drives a PFC driver enable, a global driver stop, two latched-fault flags and a one-cycle restart request to the lamp phase sequencer.

Over-voltage on the bus monitor pauses PFC switching through a hysteretic gate that never latches. An open feedback divider shows up as bus over-voltage together with a low inverting input. That fault latches, as does choke saturation, which is seen on the current sense once a leading-edge blanking window has passed. Only a supply-level reset clears a latched fault. Pulling the bus monitor very low shuts everything down without latching. When the monitor comes back up, the block asks for a new pre-heat sequence, but only if no latched fault is present.

Top module: `pfc_prot_sup`

## Requirements
- R1: When a bus sample above 3400 mV is taken, `pfc_en` is low from the next cycle on. A sample of exactly 3400 mV does not trigger the gate, and the over-voltage gate alone never raises `drv_stop`.
- R2: Once gated by over-voltage, `pfc_en` stays low while the bus stays between 3260 mV and 3400 mV. It returns high the cycle after a sample below 3260 mV.
- R3: A single sample with bus above 3400 mV and inverting input below 1200 mV sets `lat_open`, `drv_stop` high and `pfc_en` low from the next cycle. Either condition alone sets no latch.
- R4: `lat_open` and `lat_sat` stay set until reset, whatever the inputs do afterwards.
- R5: A current-sense sample above 1700 mV taken while `pfc_gate` is high and outside the blanking window sets `lat_sat` and `drv_stop` high from the next cycle.
- R6: Current sense is ignored while `pfc_gate` is low. It is also ignored for BLANK_CYC cycles (default 50) starting with the cycle in which `pfc_gate` rises.
- R7: A bus sample below 750 mV raises `drv_stop` and drops `pfc_en` from the next cycle, with no latch flag set. Samples from 750 mV to 800 mV keep the shutdown.
- R8: After a shutdown, the first bus sample above 800 mV releases `drv_stop` and produces a `restart_req` pulse exactly one cycle wide, both in the next cycle.
- R9: While either latch is set, a disable release produces no `restart_req` and `drv_stop` stays high.
- R10: After reset, `pfc_en` is high and `drv_stop`, `lat_open`, `lat_sat` and `restart_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset (supply-level) |
| bus_mv | input | 13 | Bus-monitor sample in mV |
| inv_mv | input | 13 | Error-amplifier inverting input sample in mV |
| cs_mv | input | 13 | PFC current-sense sample in mV |
| pfc_gate | input | 1 | PFC gate command, high while the switch is on |
| pfc_en | output | 1 | PFC driver enable |
| drv_stop | output | 1 | Stop for every driver |
| lat_open | output | 1 | Open-feedback fault latched |
| lat_sat | output | 1 | Choke-saturation fault latched |
| restart_req | output | 1 | One-cycle request for a new pre-heat sequence |

## Verification
The bench probes the threshold edges. It applies exactly 3400 mV, which must not gate. It holds the bus inside the 3260–3400 mV and 750–800 mV hysteresis bands, where a design without memory would release early. It holds the current sense high from the gate's rising edge, so that an off-by-one blanking counter latches one cycle too early or too late. It applies each open-feedback condition alone to catch a detector that uses OR instead of AND. Finally it releases the disable after a latched fault, which exposes a design that lets the restart request bypass the latch priority.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;
  parameter int MV_W = 13;
  typedef logic [MV_W-1:0] mv_t;
endpackage

// File: rtl/pfc_hyst_cmp.sv
module pfc_hyst_cmp #(
  parameter int W       = pfc_sup_pkg::MV_W,
  parameter int HI_MV   = 3400,
  parameter int LO_MV   = 3260,
  parameter bit ACT_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_l,
  input  logic [W-1:0] smp,
  output logic         q,
  output logic         rel
);
  localparam logic [W-1:0] HI_V = W'(HI_MV);
  localparam logic [W-1:0] LO_V = W'(LO_MV);

  logic set_c, clr_c, q_nxt;

  generate
    if (ACT_LOW) begin : g_low
      assign set_c = smp < LO_V;
      assign clr_c = smp > HI_V;
    end else begin : g_high
      assign set_c = smp > HI_V;
      assign clr_c = smp < LO_V;
    end
  endgenerate

  always_comb begin
    q_nxt = q;
    if (set_c)      q_nxt = 1'b1;
    else if (clr_c) q_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      q   <= 1'b0;
      rel <= 1'b0;
    end else begin
      q   <= q_nxt;
      rel <= q & ~q_nxt;
    end
  end

  // R1 and R7: a sample past the trip level arms the comparator
  a_r1_trip_sets: assert property (@(posedge clk) disable iff (!rst_l)
    set_c |=> q);
  // R2 and R7: inside the band the state holds
  a_r2_band_holds: assert property (@(posedge clk) disable iff (!rst_l)
    (q && !clr_c) |=> q);
endmodule

// File: rtl/pfc_open_fb.sv
module pfc_open_fb #(
  parameter int W      = pfc_sup_pkg::MV_W,
  parameter int OV_MV  = 3400,
  parameter int INV_MV = 1200
) (
  input  logic         clk,
  input  logic         rst_l,
  input  logic [W-1:0] bus,
  input  logic [W-1:0] inv,
  output logic         lat
);
  localparam logic [W-1:0] OV_V  = W'(OV_MV);
  localparam logic [W-1:0] INV_V = W'(INV_MV);

  logic hit, lat_nxt;

  assign hit = (bus > OV_V) && (inv < INV_V);

  always_comb lat_nxt = lat | hit;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) lat <= 1'b0;
    else        lat <= lat_nxt;
  end

  a_r4_open_sticky: assert property (@(posedge clk) disable iff (!rst_l)
    lat |=> lat);
  a_r3_open_needs_both: assert property (@(posedge clk) disable iff (!rst_l)
    (!lat && !(bus > OV_V)) |=> !lat);
endmodule

// File: rtl/pfc_sat_guard.sv
module pfc_sat_guard #(
  parameter int W         = pfc_sup_pkg::MV_W,
  parameter int SAT_MV    = 1700,
  parameter int BLANK_CYC = 50
) (
  input  logic         clk,
  input  logic         rst_l,
  input  logic         gate,
  input  logic [W-1:0] cs,
  output logic         lat
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [W-1:0]  SAT_V = W'(SAT_MV);
  localparam logic [CW-1:0] LOAD  = CW'(BLANK_CYC - 1);

  logic          gate_d, rise, blank, hit, lat_nxt;
  logic [CW-1:0] cnt, cnt_nxt;

  assign rise  = gate & ~gate_d;
  assign blank = rise | (cnt != '0);
  assign hit   = gate & ~blank & (cs > SAT_V);

  always_comb begin
    cnt_nxt = cnt;
    if (rise)             cnt_nxt = LOAD;
    else if (cnt != '0)   cnt_nxt = cnt - 1'b1;
    lat_nxt = lat | hit;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      gate_d <= 1'b0;
      cnt    <= '0;
      lat    <= 1'b0;
    end else begin
      gate_d <= gate;
      cnt    <= cnt_nxt;
      lat    <= lat_nxt;
    end
  end

  // R6: the rising-edge cycle never trips the latch
  a_r6_edge_blanked: assert property (@(posedge clk) disable iff (!rst_l)
    (!lat && rise) |=> !lat);
  a_r6_gate_low_ignored: assert property (@(posedge clk) disable iff (!rst_l)
    (!lat && !gate) |=> !lat);
  a_r4_sat_sticky: assert property (@(posedge clk) disable iff (!rst_l)
    lat |=> lat);
endmodule

// File: rtl/pfc_prot_sup.sv
module pfc_prot_sup #(
  parameter int W         = pfc_sup_pkg::MV_W,
  parameter int OV_HI_MV  = 3400,
  parameter int OV_LO_MV  = 3260,
  parameter int OPEN_MV   = 1200,
  parameter int SAT_MV    = 1700,
  parameter int DIS_LO_MV = 750,
  parameter int DIS_HI_MV = 800,
  parameter int BLANK_CYC = 50
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_mv,
  input  logic [W-1:0] inv_mv,
  input  logic [W-1:0] cs_mv,
  input  logic         pfc_gate,
  output logic         pfc_en,
  output logic         drv_stop,
  output logic         lat_open,
  output logic         lat_sat,
  output logic         restart_req
);
  logic rst_s1, rst_l;
  logic ov_q, ov_rel_unused, dis_q, dis_rel, latched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_l  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_l  <= rst_s1;
    end
  end

  pfc_hyst_cmp #(.W(W), .HI_MV(OV_HI_MV), .LO_MV(OV_LO_MV), .ACT_LOW(1'b0)) u_ov (
    .clk(clk), .rst_l(rst_l), .smp(bus_mv), .q(ov_q), .rel(ov_rel_unused));

  pfc_hyst_cmp #(.W(W), .HI_MV(DIS_HI_MV), .LO_MV(DIS_LO_MV), .ACT_LOW(1'b1)) u_dis (
    .clk(clk), .rst_l(rst_l), .smp(bus_mv), .q(dis_q), .rel(dis_rel));

  pfc_open_fb #(.W(W), .OV_MV(OV_HI_MV), .INV_MV(OPEN_MV)) u_open (
    .clk(clk), .rst_l(rst_l), .bus(bus_mv), .inv(inv_mv), .lat(lat_open));

  pfc_sat_guard #(.W(W), .SAT_MV(SAT_MV), .BLANK_CYC(BLANK_CYC)) u_sat (
    .clk(clk), .rst_l(rst_l), .gate(pfc_gate), .cs(cs_mv), .lat(lat_sat));

  // R9: latched faults outrank the unlatched disable and the over-voltage gate
  assign latched     = lat_open | lat_sat;
  assign drv_stop    = latched | dis_q;
  assign pfc_en      = ~drv_stop & ~ov_q;
  assign restart_req = dis_rel & ~latched;

  a_r7_disable_stops: assert property (@(posedge clk) disable iff (!rst_l)
    (bus_mv < W'(DIS_LO_MV)) |=> (drv_stop && !pfc_en));
  a_r8_restart_single: assert property (@(posedge clk) disable iff (!rst_l)
    restart_req |=> !restart_req);
  a_r1_ov_gates: assert property (@(posedge clk) disable iff (!rst_l)
    (bus_mv > W'(OV_HI_MV)) |=> !pfc_en);
  a_r9_latched_keeps_stop: assert property (@(posedge clk) disable iff (!rst_l)
    latched |=> (drv_stop && !restart_req));
endmodule

// File: tb/tb_pfc_prot_sup.sv
module tb_pfc_prot_sup;
  localparam int W = pfc_sup_pkg::MV_W;
  localparam int BLANK = 50;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] bus_mv, inv_mv, cs_mv;
  logic pfc_gate;
  logic pfc_en, drv_stop, lat_open, lat_sat, restart_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pfc_prot_sup #(.BLANK_CYC(BLANK)) dut (
    .clk(clk), .rst_n(rst_n), .bus_mv(bus_mv), .inv_mv(inv_mv), .cs_mv(cs_mv),
    .pfc_gate(pfc_gate), .pfc_en(pfc_en), .drv_stop(drv_stop),
    .lat_open(lat_open), .lat_sat(lat_sat), .restart_req(restart_req));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic nominal();
    bus_mv = W'(2500); inv_mv = W'(2500); cs_mv = '0; pfc_gate = 1'b0;
  endtask

  task automatic do_reset();
    nominal();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 pfc_en", int'(pfc_en), 1);
    chk("R10 drv_stop", int'(drv_stop), 0);
    chk("R10 lat_open", int'(lat_open), 0);
    chk("R10 lat_sat", int'(lat_sat), 0);
    chk("R10 restart_req", int'(restart_req), 0);
  endtask

  task automatic t_overvoltage();
    do_reset();
    bus_mv = W'(3400); step(1);
    chk("R1 3400 no gate", int'(pfc_en), 1);
    bus_mv = W'(3500); step(1);
    chk("R1 gated", int'(pfc_en), 0);
    chk("R1 no drv_stop", int'(drv_stop), 0);
    bus_mv = W'(3300); step(3);
    chk("R2 band holds", int'(pfc_en), 0);
    bus_mv = W'(3200); step(1);
    chk("R2 released", int'(pfc_en), 1);
    chk("R3 ov alone no latch", int'(lat_open), 0);
  endtask

  task automatic t_open();
    do_reset();
    inv_mv = W'(1000); step(2);
    chk("R3 low inv alone", int'(lat_open), 0);
    bus_mv = W'(3500); step(1);
    chk("R3 open latched", int'(lat_open), 1);
    chk("R3 drv_stop", int'(drv_stop), 1);
    chk("R3 pfc_en", int'(pfc_en), 0);
    nominal(); step(5);
    chk("R4 open holds", int'(lat_open), 1);
    chk("R4 still stopped", int'(drv_stop), 1);
  endtask

  task automatic t_sat();
    do_reset();
    cs_mv = W'(1800); step(5);
    chk("R6 gate low ignored", int'(lat_sat), 0);
    pfc_gate = 1'b1;
    step(BLANK);
    chk("R6 blanked window", int'(lat_sat), 0);
    step(1);
    chk("R5 sat latched", int'(lat_sat), 1);
    chk("R5 drv_stop", int'(drv_stop), 1);
    nominal(); step(5);
    chk("R4 sat holds", int'(lat_sat), 1);
  endtask

  task automatic t_sat_below();
    do_reset();
    pfc_gate = 1'b1; cs_mv = W'(1700); step(BLANK + 5);
    chk("R5 at threshold no trip", int'(lat_sat), 0);
    pfc_gate = 1'b0; step(1);
    pfc_gate = 1'b1; cs_mv = W'(1900); step(BLANK - 1);
    chk("R6 re-blank on new edge", int'(lat_sat), 0);
    cs_mv = W'(100); step(3);
    chk("R6 low after window", int'(lat_sat), 0);
  endtask

  task automatic t_disable();
    do_reset();
    bus_mv = W'(700); step(1);
    chk("R7 drv_stop", int'(drv_stop), 1);
    chk("R7 pfc_en", int'(pfc_en), 0);
    chk("R7 no latch", int'(lat_open | lat_sat), 0);
    bus_mv = W'(780); step(3);
    chk("R7 band holds", int'(drv_stop), 1);
    chk("R8 no early restart", int'(restart_req), 0);
    bus_mv = W'(850); step(1);
    chk("R8 restart pulse", int'(restart_req), 1);
    chk("R8 drv_stop released", int'(drv_stop), 0);
    step(1);
    chk("R8 pulse one cycle", int'(restart_req), 0);
    chk("R8 pfc_en back", int'(pfc_en), 1);
  endtask

  task automatic t_priority();
    do_reset();
    bus_mv = W'(3600); inv_mv = W'(900); step(1);
    nominal(); step(2);
    chk("R9 latch set", int'(lat_open), 1);
    chk("R9 ov cleared still off", int'(pfc_en), 0);
    bus_mv = W'(600); step(2);
    bus_mv = W'(900); step(1);
    chk("R9 no restart", int'(restart_req), 0);
    chk("R9 stop held", int'(drv_stop), 1);
    step(1);
    chk("R9 no restart later", int'(restart_req), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    nominal();
    t_reset();
    t_overvoltage();
    t_open();
    t_sat();
    t_sat_below();
    t_disable();
    t_priority();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule